// File: doc/BRIEF.md
# Successive-Approximation Conversion Timer

This block paces a successive-approximation analog-to-digital conversion. It takes a fast bus clock and derives a slower conversion clock from a programmable prescaler. On a start request it first runs a two-part sampling window, with the sample-and-hold tracking the input. It then runs one binary trial per conversion clock. The trials begin at the most significant bit. In each trial the block drives a trial code to an external DAC and reads back a one-bit comparator decision.

When the last trial resolves, the block latches the final code and raises a one-cycle completion strobe. The conversion runs at 10-bit or 8-bit resolution. An 8-bit code is placed in the upper eight bits of the 10-bit result.

The block is purely a control core; the multiplexer, sample-and-hold, DAC and comparator sit outside it. The result is a plain held register with a completion pulse. It has no valid/ready handshake, because nothing downstream can stall an analog conversion. The result simply stays valid until the next completed conversion overwrites it.

Top module: `sar_conv_timer`

## Requirements
- R1: One conversion-clock period lasts 2*(prescale+1) bus cycles, where prescale is the 5-bit `prescale` input, so the prescale values 0 to 31 give periods of 2 to 64 bus cycles.
- R2: After a start, `sampling` is high for 2 conversion clocks, then for a further 2, 4, 8 or 16 conversion clocks chosen by `smp_sel` = 0, 1, 2, 3. `dac_code` is zero throughout this window.
- R3: After sampling, one trial runs per conversion clock, starting at bit 9 and moving down. During a trial, `dac_code` shows the bits already decided, with the bit under trial set to 1. A bit is kept when `cmp_hi` (high meaning the DAC level exceeds the input) is low at the end of its trial and cleared when it is high.
- R4: With `res8`=0, ten trials run (bits 9 to 0). With `res8`=1, eight trials run (bits 9 to 2) and bits 1:0 of `dac_code` and `result` stay zero.
- R5: `done` is high for exactly one cycle: the cycle after the bus edge lying 2*(prescale+1)*(2+second-phase length+trial count) bus cycles after the edge that accepted the start. `result` takes the final code at that same edge and changes at no other time.
- R6: `busy` is high from the cycle after an accepted start through the `done` cycle and low in the cycle after `done`.
- R7: A start that arrives while busy restarts the conversion from its beginning, with the R5 timing counted from the new start.
- R8: `abort` ends any conversion in progress: `busy` is low in the next cycle, no `done` follows, and `result` keeps its old value. When `abort` and `start` are high together, `abort` wins and nothing starts.
- R9: A change of `prescale`, `smp_sel` or `res8` from one cycle to the next acts exactly like `abort` (R8), including over a `start` in the same cycle.
- R10: The prescaler restarts its count on every accepted start and on every abort, so conversion timing never depends on the divider phase left by earlier activity.
- R11: After reset, `busy`, `done` and `sampling` are low and `dac_code` and `result` are zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin (or restart) a conversion, sampled each bus cycle |
| abort | input | 1 | Cancel any conversion in progress |
| prescale | input | 5 | Conversion-clock divider setting |
| smp_sel | input | 2 | Second sampling phase length select |
| res8 | input | 1 | 1 selects 8-bit resolution, 0 selects 10-bit |
| cmp_hi | input | 1 | Comparator: DAC level above the sampled input |
| sampling | output | 1 | Sample-and-hold tracking window |
| dac_code | output | 10 | Trial code driven to the DAC |
| busy | output | 1 | Conversion in progress |
| done | output | 1 | One-cycle completion strobe |
| result | output | 10 | Last completed conversion code |

## Verification
The hardest situation to reach is a conversion that has run far into its trial sequence and is then cut short. The cut may come from a restart, an abort, or a one-cycle change of a configuration field. After it, the bench must confirm that the held result and the later timing are untouched by the partial run. The stimulus reaches it by starting conversions at several prescaler settings and then interrupting them mid-trial. It then follows every interruption with a full conversion whose start-to-done distance is measured against the formula. The comparator is an ideal behavioural model fed from the live DAC code, and input codes of 0, all ones, and the half-scale values on either side exercise every keep/clear decision.

// File: rtl/sar_pkg.sv
package sar_pkg;

  typedef enum logic [2:0] {
    ST_IDLE  = 3'd0,
    ST_SMP1  = 3'd1,
    ST_SMP2  = 3'd2,
    ST_CONV  = 3'd3,
    ST_DONE  = 3'd4
  } sar_state_e;

  // Fixed length of the first sampling phase, in conversion clocks.
  localparam int unsigned SMP1_TICKS = 2;

endpackage

// File: rtl/sar_prescaler.sv
module sar_prescaler #(
  parameter int unsigned PRS_W = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic [PRS_W-1:0] prs,
  output logic             tick
);
  localparam int unsigned CNT_W = PRS_W + 1;

  logic [CNT_W-1:0] cnt;
  logic [CNT_W-1:0] lim;

  // Period is 2*(prs+1) bus cycles: terminal count is 2*prs+1.
  assign lim  = {prs, 1'b1};
  assign tick = (cnt == lim);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt <= '0;
    end else if (clr || tick) begin
      cnt <= '0;
    end else begin
      cnt <= cnt + CNT_W'(1);
    end
  end
endmodule

// File: rtl/sar_phase_ctrl.sv
module sar_phase_ctrl
  import sar_pkg::*;
#(
  parameter int unsigned RES_MAX = 10,
  parameter int unsigned RES_MIN = 8,
  parameter int unsigned SMP_W   = 2,
  localparam int unsigned IDX_W  = $clog2(RES_MAX),
  localparam int unsigned SMP2_MAX = 2 << ((1 << SMP_W) - 1),
  localparam int unsigned PH_W   = $clog2((RES_MAX > SMP2_MAX) ? RES_MAX : SMP2_MAX) + 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             go,
  input  logic             kill,
  input  logic             tick,
  input  logic [SMP_W-1:0] smp_sel,
  input  logic             res8,
  output sar_state_e       state,
  output logic [IDX_W-1:0] trial_idx,
  output logic             load_msb,
  output logic             trial_en,
  output logic             last_trial
);
  logic [PH_W-1:0] ph;
  logic [PH_W-1:0] smp2_end;
  logic [PH_W-1:0] conv_end;
  logic            smp1_last;
  logic            smp2_last;
  logic            hold_off;

  assign smp2_end   = (PH_W'(2) << smp_sel) - PH_W'(1);
  assign conv_end   = res8 ? PH_W'(RES_MIN - 1) : PH_W'(RES_MAX - 1);
  assign smp1_last  = (ph == PH_W'(SMP1_TICKS - 1));
  assign smp2_last  = (ph == smp2_end);
  assign last_trial = (ph == conv_end);
  assign trial_idx  = ph[IDX_W-1:0];
  assign hold_off   = go || kill;

  assign load_msb = (state == ST_SMP2) && tick && smp2_last && !hold_off;
  assign trial_en = (state == ST_CONV) && tick && !hold_off;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= ST_IDLE;
      ph    <= '0;
    end else if (kill) begin
      state <= ST_IDLE;
      ph    <= '0;
    end else if (go) begin
      state <= ST_SMP1;
      ph    <= '0;
    end else begin
      unique case (state)
        ST_SMP1: if (tick) begin
          if (smp1_last) begin
            state <= ST_SMP2;
            ph    <= '0;
          end else begin
            ph <= ph + PH_W'(1);
          end
        end
        ST_SMP2: if (tick) begin
          if (smp2_last) begin
            state <= ST_CONV;
            ph    <= '0;
          end else begin
            ph <= ph + PH_W'(1);
          end
        end
        ST_CONV: if (tick) begin
          if (last_trial) begin
            state <= ST_DONE;
            ph    <= '0;
          end else begin
            ph <= ph + PH_W'(1);
          end
        end
        ST_DONE: state <= ST_IDLE;
        default: state <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/sar_bit_engine.sv
module sar_bit_engine #(
  parameter int unsigned RES_MAX = 10,
  localparam int unsigned IDX_W  = $clog2(RES_MAX)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               clr,
  input  logic               load_msb,
  input  logic               trial_en,
  input  logic               last,
  input  logic [IDX_W-1:0]   idx,
  input  logic               cmp_hi,
  output logic [RES_MAX-1:0] sar,
  output logic [RES_MAX-1:0] result
);
  logic [RES_MAX-1:0] sar_nxt;

  // Bit i is under trial when idx == RES_MAX-1-i; it is armed as the
  // following trial bit when idx == RES_MAX-2-i and the trial is not last.
  for (genvar i = 0; i < RES_MAX; i++) begin : g_bit
    localparam int unsigned OWN_IDX = RES_MAX - 1 - i;
    logic on_trial;
    logic arm_next;

    assign on_trial = (idx == IDX_W'(OWN_IDX));
    if (i + 1 < RES_MAX) begin : g_arm
      assign arm_next = (idx == IDX_W'(OWN_IDX - 1)) && !last;
    end else begin : g_top
      assign arm_next = 1'b0;
    end

    always_comb begin
      sar_nxt[i] = sar[i];
      if (clr) begin
        sar_nxt[i] = 1'b0;
      end else if (load_msb) begin
        sar_nxt[i] = (i == RES_MAX - 1);
      end else if (trial_en) begin
        if (on_trial) begin
          sar_nxt[i] = !cmp_hi;
        end else if (arm_next) begin
          sar_nxt[i] = 1'b1;
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sar    <= '0;
      result <= '0;
    end else begin
      sar <= sar_nxt;
      if (trial_en && last) begin
        result <= sar_nxt;
      end
    end
  end
endmodule

// File: rtl/sar_conv_timer.sv
module sar_conv_timer
  import sar_pkg::*;
#(
  parameter int unsigned PRS_W   = 5,
  parameter int unsigned SMP_W   = 2,
  parameter int unsigned RES_MAX = 10,
  parameter int unsigned RES_MIN = 8
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               start,
  input  logic               abort,
  input  logic [PRS_W-1:0]   prescale,
  input  logic [SMP_W-1:0]   smp_sel,
  input  logic               res8,
  input  logic               cmp_hi,
  output logic               sampling,
  output logic [RES_MAX-1:0] dac_code,
  output logic               busy,
  output logic               done,
  output logic [RES_MAX-1:0] result
);
  localparam int unsigned IDX_W = $clog2(RES_MAX);
  localparam int unsigned CFG_W = PRS_W + SMP_W + 1;

  logic [CFG_W-1:0] cfg_now;
  logic [CFG_W-1:0] cfg_q;
  logic             cfg_chg;
  logic             kill;
  logic             go;
  logic             tick;
  sar_state_e       state;
  logic [IDX_W-1:0] trial_idx;
  logic             load_msb;
  logic             trial_en;
  logic             last_trial;

  assign cfg_now = {prescale, smp_sel, res8};
  assign cfg_chg = (cfg_now != cfg_q);
  assign kill    = abort || cfg_chg;
  assign go      = start && !kill;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cfg_q <= '0;
    else        cfg_q <= cfg_now;
  end

  sar_prescaler #(.PRS_W(PRS_W)) u_div (
    .clk   (clk),
    .rst_n (rst_n),
    .clr   (go || kill),
    .prs   (prescale),
    .tick  (tick)
  );

  sar_phase_ctrl #(
    .RES_MAX (RES_MAX),
    .RES_MIN (RES_MIN),
    .SMP_W   (SMP_W)
  ) u_ctrl (
    .clk        (clk),
    .rst_n      (rst_n),
    .go         (go),
    .kill       (kill),
    .tick       (tick),
    .smp_sel    (smp_sel),
    .res8       (res8),
    .state      (state),
    .trial_idx  (trial_idx),
    .load_msb   (load_msb),
    .trial_en   (trial_en),
    .last_trial (last_trial)
  );

  sar_bit_engine #(.RES_MAX(RES_MAX)) u_bits (
    .clk      (clk),
    .rst_n    (rst_n),
    .clr      (go),
    .load_msb (load_msb),
    .trial_en (trial_en),
    .last     (last_trial),
    .idx      (trial_idx),
    .cmp_hi   (cmp_hi),
    .sar      (dac_code),
    .result   (result)
  );

  assign busy     = (state != ST_IDLE);
  assign done     = (state == ST_DONE);
  assign sampling = (state == ST_SMP1) || (state == ST_SMP2);
endmodule

// File: rtl/sar_conv_timer_chk.sv
module sar_conv_timer_chk #(
  parameter int unsigned PRS_W   = 5,
  parameter int unsigned SMP_W   = 2,
  parameter int unsigned RES_MAX = 10,
  parameter int unsigned RES_MIN = 8
) (
  input logic               clk,
  input logic               rst_n,
  input logic               start,
  input logic               abort,
  input logic [PRS_W-1:0]   prescale,
  input logic [SMP_W-1:0]   smp_sel,
  input logic               res8,
  input logic               sampling,
  input logic [RES_MAX-1:0] dac_code,
  input logic               busy,
  input logic               done,
  input logic [RES_MAX-1:0] result
);
  localparam int unsigned LOW_W = RES_MAX - RES_MIN;

  p_done_single_r5: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  p_result_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !done |-> $stable(result));

  p_done_busy_r6: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> busy);

  p_sample_dac_r2: assert property (@(posedge clk) disable iff (!rst_n)
    sampling |-> (dac_code == '0));

  p_final_code_r3: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (result == dac_code));

  p_low_bits_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (done && res8) |-> (result[LOW_W-1:0] == '0));

  p_abort_stop_r8: assert property (@(posedge clk) disable iff (!rst_n)
    abort |=> !busy);

  p_restart_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !abort && $stable(prescale) && $stable(smp_sel) && $stable(res8))
      |=> (busy && sampling && !done));

  p_cfg_abort_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(smp_sel) |=> !busy);
endmodule

bind sar_conv_timer sar_conv_timer_chk #(
  .PRS_W   (PRS_W),
  .SMP_W   (SMP_W),
  .RES_MAX (RES_MAX),
  .RES_MIN (RES_MIN)
) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .start    (start),
  .abort    (abort),
  .prescale (prescale),
  .smp_sel  (smp_sel),
  .res8     (res8),
  .sampling (sampling),
  .dac_code (dac_code),
  .busy     (busy),
  .done     (done),
  .result   (result)
);

// File: tb/sar_conv_timer_test.sv
`timescale 1ns/1ps
module sar_conv_timer_test;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       start = 1'b0;
  logic       abort = 1'b0;
  logic [4:0] prescale = '0;
  logic [1:0] smp_sel = '0;
  logic       res8 = 1'b0;
  logic       cmp_hi;
  logic       sampling;
  logic [9:0] dac_code;
  logic       busy;
  logic       done;
  logic [9:0] result;
  logic [9:0] vin = '0;

  int errors = 0;
  int checks = 0;
  string phase_tag = "R11";

  always #2.5 clk = ~clk;

  // Ideal comparator: high when the DAC level exceeds the held input.
  assign cmp_hi = (dac_code > vin);

  sar_conv_timer uut (
    .clk(clk), .rst_n(rst_n), .start(start), .abort(abort),
    .prescale(prescale), .smp_sel(smp_sel), .res8(res8), .cmp_hi(cmp_hi),
    .sampling(sampling), .dac_code(dac_code), .busy(busy), .done(done),
    .result(result)
  );

  // ---------------- behavioural reference model ----------------
  bit         m_busy = 0;
  int         m_cnt = 0, m_P = 2, m_Ps = 0, m_T = 0;
  logic [9:0] m_res = '0, m_exp = '0;
  logic [4:0] q_prs = '0;
  logic [1:0] q_smp = '0;
  logic       q_res = 1'b0;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_busy = 0; m_res = '0; q_prs = '0; q_smp = '0; q_res = 1'b0;
    end else begin
      bit chg;
      chg = (prescale != q_prs) || (smp_sel != q_smp) || (res8 != q_res);
      q_prs = prescale; q_smp = smp_sel; q_res = res8;
      if (abort || chg) begin
        m_busy = 0;                       // R8, R9
      end else if (start) begin
        int n2, nb;
        n2 = 2 << smp_sel;
        nb = res8 ? 8 : 10;
        m_P  = 2 * (int'(prescale) + 1);  // R1
        m_Ps = m_P * (2 + n2);            // R2
        m_T  = m_P * (2 + n2 + nb);       // R5
        m_exp = res8 ? (vin & 10'h3FC) : vin;
        m_busy = 1; m_cnt = 0;
      end else if (m_busy) begin
        if (m_cnt == m_T) m_busy = 0;
        else begin
          m_cnt++;
          if (m_cnt == m_T) m_res = m_exp;
        end
      end
    end
  end

  function automatic logic [9:0] exp_dac();
    int b;
    logic [9:0] above;
    if (m_cnt < m_Ps) return '0;
    if (m_cnt == m_T) return m_exp;
    b = 9 - (m_cnt - m_Ps) / m_P;
    above = ~((10'd1 << (b + 1)) - 10'd1);
    return (m_exp & above) | (10'd1 << b);
  endfunction

  task automatic chk(input string req, input logic [9:0] act, input logic [9:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s (%s) actual=%h expected=%h at %0t", req, phase_tag, act, exp, $time);
    end
  endtask

  // Per-cycle comparison, away from the active edge.
  always @(negedge clk) begin
    if (rst_n) begin
      chk("R6 busy", {9'd0, busy}, {9'd0, m_busy});
      chk("R5 done", {9'd0, done}, {9'd0, (m_busy && m_cnt == m_T)});
      chk("R2 sampling", {9'd0, sampling}, {9'd0, (m_busy && m_cnt < m_Ps)});
      if (m_busy) chk("R3 dac_code", dac_code, exp_dac());
      chk("R5 result", result, m_res);
    end
  end

  // Watchdog
  int cyc_total = 0;
  always @(posedge clk) begin
    cyc_total++;
    if (cyc_total > 150000) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  task automatic set_cfg(input logic [4:0] p, input logic [1:0] s, input logic r, input logic [9:0] v);
    @(negedge clk);
    prescale = p; smp_sel = s; res8 = r; vin = v;
    @(negedge clk);
  endtask

  task automatic pulse_start();
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
  endtask

  // Full conversion with a measured start-to-done distance (R1, R5).
  task automatic run_conv(input logic [4:0] p, input logic [1:0] s, input logic r, input logic [9:0] v);
    int cyc, tgt;
    tgt = 2 * (int'(p) + 1) * (2 + (2 << s) + (r ? 8 : 10)) + 1;
    set_cfg(p, s, r, v);
    pulse_start();
    cyc = 1;
    while (!done && cyc < 5000) begin
      @(negedge clk);
      cyc++;
    end
    checks++;
    if (cyc != tgt) begin
      errors++;
      $display("FAIL R1 start-to-done cycles actual=%0d expected=%0d", cyc, tgt);
    end
    chk(r ? "R4 final code" : "R3 final code", result, r ? (v & 10'h3FC) : v);
    @(negedge clk);
    chk("R6 busy after done", {9'd0, busy}, 10'd0);
  endtask

  task automatic watch_no_done(input int n, output bit seen);
    seen = 0;
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      if (done) seen = 1;
    end
  endtask

  initial begin
    bit seen;
    logic [9:0] held;
    repeat (3) @(negedge clk);
    // R11 reset state
    chk("R11 busy", {9'd0, busy}, 10'd0);
    chk("R11 done", {9'd0, done}, 10'd0);
    chk("R11 sampling", {9'd0, sampling}, 10'd0);
    chk("R11 dac_code", dac_code, 10'd0);
    chk("R11 result", result, 10'd0);
    rst_n = 1'b1;
    @(negedge clk);

    phase_tag = "R3";  run_conv(5'd0, 2'd0, 1'b0, 10'h2A5);
    phase_tag = "R2";  run_conv(5'd0, 2'd1, 1'b0, 10'h3FF);
    phase_tag = "R4";  run_conv(5'd1, 2'd2, 1'b1, 10'h000);
    phase_tag = "R4";  run_conv(5'd3, 2'd3, 1'b1, 10'h1FF);
    phase_tag = "R3";  run_conv(5'd0, 2'd3, 1'b0, 10'h200);
    phase_tag = "R1";  run_conv(5'd31, 2'd0, 1'b0, 10'h155);
    phase_tag = "R4";  run_conv(5'd2, 2'd0, 1'b1, 10'h3FF);

    // R7 / R10: restart while busy, mid-trial, at an odd divider phase
    phase_tag = "R7";
    set_cfg(5'd2, 2'd1, 1'b0, 10'h0F3);
    pulse_start();
    repeat (37) @(negedge clk);
    vin = 10'h30C;
    run_conv(5'd2, 2'd1, 1'b0, 10'h30C);

    // R8: abort mid-conversion leaves result untouched
    phase_tag = "R8";
    held = result;
    set_cfg(5'd1, 2'd0, 1'b0, 10'h011);
    pulse_start();
    repeat (30) @(negedge clk);
    abort = 1'b1;
    @(negedge clk);
    abort = 1'b0;
    chk("R8 busy after abort", {9'd0, busy}, 10'd0);
    watch_no_done(200, seen);
    chk("R8 no done after abort", {9'd0, seen}, 10'd0);
    chk("R8 result held", result, held);

    // R8: start and abort together start nothing
    start = 1'b1; abort = 1'b1;
    @(negedge clk);
    start = 1'b0; abort = 1'b0;
    chk("R8 start+abort busy", {9'd0, busy}, 10'd0);

    // R9: configuration change mid-conversion aborts
    phase_tag = "R9";
    set_cfg(5'd0, 2'd2, 1'b0, 10'h222);
    pulse_start();
    repeat (25) @(negedge clk);
    smp_sel = 2'd1;
    @(negedge clk);
    chk("R9 busy after cfg change", {9'd0, busy}, 10'd0);
    watch_no_done(100, seen);
    chk("R9 no done after cfg change", {9'd0, seen}, 10'd0);
    chk("R9 result held", result, held);

    // R10: after the aborts, a fresh conversion keeps exact timing
    phase_tag = "R10";
    run_conv(5'd4, 2'd1, 1'b1, 10'h2FE);

    repeat (4) @(negedge clk);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule